// File: doc/BRIEF.md
# Multilevel Symbol Slicer with Timing-Error Scaling

This block works on one rail, I or Q, of a symbol-tracking receiver. Each input beat carries two signed samples. The end-of-symbol sample is sliced against evenly spaced thresholds to pick a symbol level. The order select chooses 2, 4, 8 or 16 levels per rail. The second sample is taken at the transition midpoint. The block multiplies it by the direction of the step between the previous decision and the current one, which gives the timing error. That error is then shifted left by a programmable amount so it reaches full scale before the tracking loop filter, which sits outside this block. A shift that overflows the output clamps to the nearest extreme instead of wrapping.

Samples are 16-bit two's complement, and full scale stands for ±1.0. The input and output are valid/ready streams with a single output register. The input is ready whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds still and no new beat is taken. Data moves only on a cycle where valid and ready are both high. The order and shift selects are sampled together with each accepted beat.

Top module: `mls_slicer_top`

## Requirements
- R1: `order_sel` picks the level count: 00 = 2, 01 = 4, 10 = 8, 11 = 16. `level_out` is an index from 0 (most negative level) to count−1.
- R2: For N levels, thresholds sit at k·(2/N) − 1 for k = 1..N−1, which is k·65536/N − 32768 in sample units. The index equals the number of thresholds that are less than or equal to the end-of-symbol sample, so a sample exactly on a threshold takes the upper level.
- R3: In 2-level mode the only threshold is 0: negative samples give index 0 and all others give index 1. In 4-level mode the thresholds are −16384, 0 and +16384.
- R4: When the index rises from the previous accepted beat, the unscaled error is +midpoint. When it falls, the error is −midpoint. When it stays the same, the error is 0.
- R5: The first beat accepted after reset has no previous decision, and its error is 0.
- R6: `shift_sel` sets the left shift of the error: 00 = 1, 01 = 2, 10 = 3, 11 = 4 places.
- R7: A scaled error above 32767 or below −32768 is output as 32767 or −32768. This includes the negation of −32768.
- R8: A beat accepted at one clock edge appears on `out_valid`, `level_out` and `err_out` right after that edge, with one cycle of latency.
- R9: `in_ready` equals `!out_valid || out_ready`. During a stall the outputs stay stable, and a beat that is not accepted does not change the stored previous decision.
- R10: While reset is held, `out_valid`, `level_out` and `err_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| sym_smp | input | 16 | End-of-symbol sample, signed |
| mid_smp | input | 16 | Transition-midpoint sample, signed |
| order_sel | input | 2 | Levels per rail: 2, 4, 8, 16 |
| shift_sel | input | 2 | Error left shift, 1 to 4 places |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| level_out | output | 4 | Decided level index |
| err_out | output | 16 | Scaled, saturated timing error, signed |

## Verification
The bench drives samples placed exactly on a threshold and one LSB below it. A slicer that breaks ties the wrong way, or divides the range unevenly, reports an index one off. It also drives large midpoint values under the widest shift, together with a midpoint of −32768 on a falling step. A design that wraps instead of clamping outputs an error with the wrong sign. Random stalls on `out_ready` check that the output does not change while held and that skipped beats do not update the stored previous decision; otherwise the error sign goes wrong on the next beat. The first beat after reset is checked for a zero error, which catches a design that compares against a stale or reset-valued previous level.

// File: rtl/mls_pkg.sv
package mls_pkg;
  // width of a level index: order select of 2 bits reaches 16 levels
  localparam int LVW = 4;

  typedef enum logic [1:0] {
    ORD_2  = 2'b00,
    ORD_4  = 2'b01,
    ORD_8  = 2'b10,
    ORD_16 = 2'b11
  } order_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;
endpackage

// File: rtl/mls_decide.sv
module mls_decide
  import mls_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_en,
  input  logic signed [DW-1:0] samp,
  input  order_e               ord,
  output logic [LVW-1:0]       idx
);
  // Shifting to offset binary turns the even thresholds into the top bits.
  logic [DW-1:0]  offs;
  logic [LVW-1:0] top;
  logic [1:0]     drop;

  assign offs = {~samp[DW-1], samp[DW-2:0]};
  assign top  = offs[DW-1 -: LVW];
  assign drop = 2'(LVW - 1) - ord;

  always_comb idx = top >> drop;

  // the index never reaches the level count of the selected order
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (({1'b0, idx} >> ({1'b0, ord} + 3'd1)) == 5'd0));
endmodule

// File: rtl/mls_scale.sv
module mls_scale
  import mls_pkg::*;
#(
  parameter int DW = 16,
  parameter int EW = 16
) (
  input  logic signed [DW-1:0] mid,
  input  step_e                step,
  input  logic [1:0]           sh,
  output logic signed [EW-1:0] err
);
  localparam int WW = DW + 6;
  localparam logic signed [WW-1:0] EMAX = (WW'(1) <<< (EW - 1)) - WW'(1);
  localparam logic signed [WW-1:0] EMIN = -(WW'(1) <<< (EW - 1));

  logic signed [WW-1:0] base;
  logic signed [WW-1:0] shv;
  logic [2:0]           amt;

  always_comb begin
    case (step)
      STEP_UP:   base = WW'(mid);
      STEP_DOWN: base = -WW'(mid);
      default:   base = '0;
    endcase
    amt = {1'b0, sh} + 3'd1;
    shv = base <<< amt;
    if (shv > EMAX)      err = EMAX[EW-1:0];
    else if (shv < EMIN) err = EMIN[EW-1:0];
    else                 err = shv[EW-1:0];
  end
endmodule

// File: rtl/mls_slicer_top.sv
module mls_slicer_top
  import mls_pkg::*;
#(
  parameter int DW = 16,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] sym_smp,
  input  logic [DW-1:0] mid_smp,
  input  logic [1:0]    order_sel,
  input  logic [1:0]    shift_sel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LVW-1:0] level_out,
  output logic [EW-1:0] err_out
);
  logic           acc;
  logic [LVW-1:0] cur_idx;
  logic [LVW-1:0] prev_idx;
  logic           have_prev;
  step_e          step;
  logic [EW-1:0]  err_nx;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  mls_decide #(.DW(DW)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .chk_en (in_valid),
    .samp   ($signed(sym_smp)),
    .ord    (order_e'(order_sel)),
    .idx    (cur_idx)
  );

  always_comb begin
    if (!have_prev || cur_idx == prev_idx) step = STEP_NONE;
    else if (cur_idx > prev_idx)           step = STEP_UP;
    else                                   step = STEP_DOWN;
  end

  mls_scale #(.DW(DW), .EW(EW)) u_scl (
    .mid  ($signed(mid_smp)),
    .step (step),
    .sh   (shift_sel),
    .err  (err_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      level_out <= '0;
      err_out   <= '0;
      prev_idx  <= '0;
      have_prev <= 1'b0;
    end else if (acc) begin
      out_valid <= 1'b1;
      level_out <= cur_idx;
      err_out   <= err_nx;
      prev_idx  <= cur_idx;
      have_prev <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(level_out) && $stable(err_out)));

  p_first_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !have_prev) |=> (err_out == '0));

  p_flat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && have_prev && cur_idx == prev_idx) |=> (err_out == '0));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && have_prev && cur_idx > prev_idx && $signed(mid_smp) > 0)
      |=> ($signed(err_out) > 0));
endmodule

// File: tb/sim_mls_slicer_top.sv
module sim_mls_slicer_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [15:0] sym_smp = '0;
  logic [15:0] mid_smp = '0;
  logic [1:0] order_sel = '0;
  logic [1:0] shift_sel = '0;
  logic in_ready, out_valid;
  logic [3:0] level_out;
  logic [15:0] err_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mls_slicer_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .sym_smp(sym_smp), .mid_smp(mid_smp), .order_sel(order_sel),
    .shift_sel(shift_sel), .out_valid(out_valid), .out_ready(out_ready),
    .level_out(level_out), .err_out(err_out)
  );

  // reference model
  int  m_vld, m_lvl, m_err, m_prev, m_have, m_sat;
  initial begin m_vld = 0; m_lvl = 0; m_err = 0; m_prev = 0; m_have = 0; m_sat = 0; end

  function automatic int ref_level(int s, int ord);
    int n = 2 << ord;
    return ((s + 32768) * n) / 65536;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld = 0; m_lvl = 0; m_err = 0; m_prev = 0; m_have = 0; m_sat = 0;
    end else if (in_valid && (!m_vld || out_ready)) begin
      int lv, e;
      lv = ref_level($signed(sym_smp), order_sel);
      e = 0;
      if (m_have && lv > m_prev) e = $signed(mid_smp);
      if (m_have && lv < m_prev) e = -$signed(mid_smp);
      e = e * (2 << shift_sel);
      m_sat = 0;
      if (e > 32767) begin e = 32767; m_sat = 1; end
      if (e < -32768) begin e = -32768; m_sat = 1; end
      m_err = e; m_lvl = lv; m_vld = 1;
      m_sat = m_sat | (m_have ? 0 : 2);
      m_prev = lv; m_have = 1;
    end else if (out_ready) begin
      m_vld = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R8/R9 out_valid", int'(out_valid), m_vld);
    chk("R9 in_ready", int'(in_ready), int'(!m_vld || out_ready));
    chk("R1/R2/R3 level_out", int'(level_out), m_lvl);
    if (m_sat == 1)      chk("R7 err_out", int'($signed(err_out)), m_err);
    else if (m_sat == 2) chk("R5 err_out", int'($signed(err_out)), m_err);
    else                 chk("R4/R6 err_out", int'($signed(err_out)), m_err);
  endtask

  task automatic step(bit v, int s, int m, int ord, int sh, bit ordy);
    @(negedge clk);
    compare();
    in_valid = v; sym_smp = 16'(s); mid_smp = 16'(m);
    order_sel = 2'(ord); shift_sel = 2'(sh); out_ready = ordy;
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 level_out", int'(level_out), 0);
    chk("R10 err_out", int'(err_out), 0);
    rst_n = 1'b1;
    // R5: first beat, a nonzero midpoint must still give zero error
    step(1, 20000, 1000, 1, 0, 1);
    // R3: 2-level slicing around 0
    step(1, -1, 500, 0, 0, 1);
    step(1, 0, 500, 0, 0, 1);
    step(1, 0, 500, 0, 0, 1);
    step(1, -32768, 700, 0, 1, 1);
    // R2/R3: 4-level thresholds and ties
    step(1, -16385, 100, 1, 0, 1);
    step(1, -16384, 100, 1, 0, 1);
    step(1, -1, 100, 1, 0, 1);
    step(1, 0, 100, 1, 0, 1);
    step(1, 16383, 100, 1, 0, 1);
    step(1, 16384, 100, 1, 0, 1);
    step(1, 32767, 100, 2, 0, 1);
    // R6: each shift setting
    for (int sh = 0; sh < 4; sh++) begin
      step(1, -32768, -300, 3, sh, 1);
      step(1, 32767, 300, 3, sh, 1);
    end
    // R7: clamp in both directions, and negated -32768
    step(1, -32768, 30000, 3, 3, 1);
    step(1, 32767, 30000, 3, 3, 1);
    step(1, -32768, 30000, 3, 3, 1);
    step(1, 32767, -32768, 3, 0, 1);
    step(1, -32768, -32768, 3, 0, 1);
    step(1, -32768, 0, 3, 0, 1);
    // R9: stalls; beats offered during a stall must not move the state
    step(1, 32767, 1234, 2, 1, 0);
    step(1, -32768, 999, 2, 1, 0);
    step(1, -32768, 999, 2, 1, 0);
    step(1, -32768, 999, 2, 1, 1);
    step(0, 0, 0, 2, 1, 1);
    // R1: all orders, random data and back-pressure
    for (int i = 0; i < 3000; i++) begin
      int s, m;
      s = $urandom_range(0, 65535) - 32768;
      m = $urandom_range(0, 65535) - 32768;
      if (i % 7 == 0) s = ($urandom_range(0, 15) * 4096) - 32768;
      step($urandom_range(0, 3) != 0, s, m, $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 3) != 0);
    end
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule